// File: doc/BRIEF.md
# Tiled Small-Table Unsigned Multiplier

This block multiplies an unsigned 8-bit operand by an unsigned 7-bit operand and returns the full 15-bit product. It does not build one partial-product row for each multiplier bit. Instead it cuts each operand into digit fields that are three bits wide. Where a width is not a multiple of three, the top field is narrower. Each pair of one multiplicand field and one multiplier field feeds a small sub-multiplier tile. A tile whose multiplier field is a single bit collapses to AND gating. A wider tile is a shift-add over at most three bits. Each tile result is zero-extended and moved to the weight that equals the sum of its two field offsets, and the nine weighted terms are added into the product.

Widths and digit size are parameters. By default a register stage sits between the tiles and the final adder. That stage gives one cycle of latency, and a valid flag travels through it alongside the data. If the stage is turned off, the block becomes purely combinational.

Top module: `tiled_mult`

## Requirements
- R1: With the defaults, for every pair of `op_a` in 0..255 and `op_b` in 0..127 presented with `in_valid`=1, `prod` equals the unsigned product `op_a*op_b` one clock later.
- R2: The multiplicand is cut into fields at bits [2:0], [5:3] and [7:6]. The multiplier is cut into fields at bits [2:0], [5:3] and [6]. An input that is nonzero in only one field of each operand gives the product of the two field values shifted left by the sum of the field offsets (0, 3 or 6 each).
- R3: Every combination of two fields reaches its correct weight. This covers weight 0, weight 3 (two pairs), weight 6 (three pairs), weight 9 (two pairs) and weight 12 (field [7:6] times bit [6]).
- R4: `out_valid` equals the value that `in_valid` had one clock earlier.
- R5: In the cycle after a clock edge with `rst`=1, `out_valid` is 0 and `prod` is 0, whatever the inputs were.
- R6: A zero value on either operand yields a zero product.
- R7: The largest operands, 255 and 127, give 32385. The result is not truncated in the 15-bit output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the operands as meaningful |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 7 | Unsigned multiplier |
| out_valid | output | 1 | `in_valid` delayed by the register stage |
| prod | output | 15 | Unsigned product |

## Verification
The directed vectors place ones in exactly one field of each operand. A tile that was wired to the wrong field, or shifted by the wrong amount, would therefore show up as a product off by a clean power of two, or as a missing term. Two boundaries get their own checks. The single-bit top multiplier field and the two-bit top multiplicand field are exercised together at weight 12, where a gated tile with its inputs crossed would drop the result. All-ones operands would expose a narrow adder or a truncated tile output. A full sweep of all 32768 operand pairs catches carry errors between overlapping terms. The valid and reset checks look for a register stage that leaks stale data or drifts by a cycle.

// File: rtl/smt_pkg.sv
package smt_pkg;

    // Digit fields are never wider than this; the tile helper loops to it.
    localparam int MAX_DIG = 8;

    typedef enum logic [0:0] {
        TILE_GATE = 1'b0,   // one side is a single bit: AND gating
        TILE_FULL = 1'b1    // both sides multi-bit: shift-add table
    } tile_kind_e;

    // number of digit fields needed to cover a word
    function automatic int num_fields(input int width, input int dig);
        return (width + dig - 1) / dig;
    endfunction

    // width of field idx (the top field may be short)
    function automatic int field_width(input int width, input int dig, input int idx);
        int rest;
        rest = width - idx * dig;
        return (rest < dig) ? rest : dig;
    endfunction

    function automatic tile_kind_e kind_of(input int aw, input int bw);
        return (aw == 1 || bw == 1) ? TILE_GATE : TILE_FULL;
    endfunction

    // small product of two digits, written as a bounded shift-add
    function automatic logic [2*MAX_DIG-1:0] tile_mul(
        input logic [MAX_DIG-1:0] a,
        input logic [MAX_DIG-1:0] b,
        input int                 bw
    );
        logic [2*MAX_DIG-1:0] acc;
        acc = '0;
        for (int i = 0; i < MAX_DIG; i++) begin
            if (i < bw && b[i]) begin
                acc = acc + ({{MAX_DIG{1'b0}}, a} << i);
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/smt_tile.sv
module smt_tile
    import smt_pkg::*;
#(
    parameter int AW = 3,
    parameter int BW = 3
) (
    input  logic [AW-1:0]    a,
    input  logic [BW-1:0]    b,
    output logic [AW+BW-1:0] p
);
    localparam tile_kind_e KIND = kind_of(AW, BW);

    generate
        if (KIND == TILE_GATE && BW == 1) begin : g_gate_b
            assign p = {{BW{1'b0}}, a & {AW{b[0]}}};
        end else if (KIND == TILE_GATE) begin : g_gate_a
            assign p = {{AW{1'b0}}, b & {BW{a[0]}}};
        end else begin : g_full
            logic [2*MAX_DIG-1:0] full;
            assign full = tile_mul(MAX_DIG'(a), MAX_DIG'(b), BW);
            assign p    = full[AW+BW-1:0];
        end
    endgenerate
endmodule

// File: rtl/smt_tile_array.sv
module smt_tile_array
    import smt_pkg::*;
#(
    parameter int A_W   = 8,
    parameter int B_W   = 7,
    parameter int DIG_W = 3,
    localparam int P_W  = A_W + B_W,
    localparam int NA   = num_fields(A_W, DIG_W),
    localparam int NB   = num_fields(B_W, DIG_W),
    localparam int N_T  = NA * NB
) (
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    output logic [P_W-1:0] terms [N_T]
);
    generate
        for (genvar ia = 0; ia < NA; ia++) begin : g_row
            for (genvar jb = 0; jb < NB; jb++) begin : g_col
                localparam int AWI = field_width(A_W, DIG_W, ia);
                localparam int BWJ = field_width(B_W, DIG_W, jb);
                localparam int SH  = (ia + jb) * DIG_W;
                logic [AWI+BWJ-1:0] tp;

                smt_tile #(.AW(AWI), .BW(BWJ)) u_tile (
                    .a (op_a[ia*DIG_W +: AWI]),
                    .b (op_b[jb*DIG_W +: BWJ]),
                    .p (tp)
                );

                assign terms[ia*NB + jb] = P_W'(tp) << SH;
            end
        end
    endgenerate
endmodule

// File: rtl/smt_sum.sv
module smt_sum #(
    parameter int P_W = 15,
    parameter int N_T = 9
) (
    input  logic [P_W-1:0] terms [N_T],
    output logic [P_W-1:0] total
);
    always_comb begin
        total = '0;
        for (int k = 0; k < N_T; k++) begin
            total = total + terms[k];
        end
    end
endmodule

// File: rtl/tiled_mult.sv
module tiled_mult
    import smt_pkg::*;
#(
    parameter int A_W      = 8,
    parameter int B_W      = 7,
    parameter int DIG_W    = 3,
    parameter bit TILE_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [A_W-1:0]       op_a,
    input  logic [B_W-1:0]       op_b,
    output logic                 out_valid,
    output logic [A_W+B_W-1:0]   prod
);
    localparam int P_W = A_W + B_W;
    localparam int N_T = num_fields(A_W, DIG_W) * num_fields(B_W, DIG_W);

    logic [P_W-1:0] terms_d [N_T];
    logic [P_W-1:0] terms_q [N_T];

    smt_tile_array #(.A_W(A_W), .B_W(B_W), .DIG_W(DIG_W)) u_tiles (
        .op_a  (op_a),
        .op_b  (op_b),
        .terms (terms_d)
    );

    generate
        if (TILE_REG) begin : g_stage
            logic valid_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    for (int k = 0; k < N_T; k++) terms_q[k] <= '0;
                end else begin
                    valid_q <= in_valid;
                    for (int k = 0; k < N_T; k++) terms_q[k] <= terms_d[k];
                end
            end
            assign out_valid = valid_q;
        end else begin : g_flow
            assign terms_q   = terms_d;
            assign out_valid = in_valid;
        end
    endgenerate

    smt_sum #(.P_W(P_W), .N_T(N_T)) u_sum (
        .terms (terms_q),
        .total (prod)
    );
endmodule

// File: rtl/smt_check.sv
module smt_check #(
    parameter int A_W     = 8,
    parameter int B_W     = 7,
    parameter bit REG_LAT = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [A_W-1:0]       op_a,
    input logic [B_W-1:0]       op_b,
    input logic                 out_valid,
    input logic [A_W+B_W-1:0]   prod
);
    localparam int P_W = A_W + B_W;

    generate
        if (REG_LAT) begin : g_lat1
            // R1 product of the operands seen one edge earlier
            a_r1_product: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> prod == P_W'($past(op_a)) * P_W'($past(op_b)));
            // R4 valid follows input valid by one edge
            a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> out_valid == $past(in_valid));
            // R5 reset clears the stage
            a_r5_reset_clear: assert property (@(posedge clk)
                rst |=> (!out_valid && prod == '0));
            // R6 zero operand gives zero
            a_r6_zero_operand: assert property (@(posedge clk) disable iff (rst)
                (out_valid && ($past(op_a) == '0 || $past(op_b) == '0)) |-> prod == '0);
        end else begin : g_lat0
            a_r1_product: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> prod == P_W'(op_a) * P_W'(op_b));
            a_r4_valid_delay: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
            a_r6_zero_operand: assert property (@(posedge clk) disable iff (rst)
                (op_a == '0 || op_b == '0) |-> prod == '0);
            a_r7_upper_bound: assert property (@(posedge clk) disable iff (rst)
                prod <= P_W'({A_W{1'b1}}) * P_W'({B_W{1'b1}}));
        end
    endgenerate
endmodule

bind tiled_mult smt_check #(.A_W(A_W), .B_W(B_W), .REG_LAT(TILE_REG)) u_smt_check (.*);

// File: tb/tiled_mult_bench.sv
module tiled_mult_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [6:0]  op_b = '0;
    logic        out_valid;
    logic [14:0] prod;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiled_mult u_tiled_mult (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .prod(prod)
    );

    // a, b, expected product (hand-computed from the field weights)
    localparam logic [29:0] VEC [N_VEC] = '{
        {8'd0,   7'd0,   15'd0},      // R6
        {8'd255, 7'd127, 15'd32385},  // R7
        {8'd7,   7'd7,   15'd49},     // R2 weight 0
        {8'd56,  7'd7,   15'd392},    // R3 weight 3, a mid
        {8'd7,   7'd56,  15'd392},    // R3 weight 3, b mid
        {8'd192, 7'd7,   15'd1344},   // R3 weight 6, a top
        {8'd56,  7'd56,  15'd3136},   // R3 weight 6, both mid
        {8'd7,   7'd64,  15'd448},    // R3 weight 6, b top
        {8'd192, 7'd56,  15'd10752},  // R3 weight 9
        {8'd56,  7'd64,  15'd3584},   // R3 weight 9
        {8'd192, 7'd64,  15'd12288},  // R2 weight 12
        {8'd128, 7'd64,  15'd8192},   // R2 top field upper bit
        {8'd170, 7'd85,  15'd14450},  // R1 mixed
        {8'd1,   7'd1,   15'd1},      // R1
        {8'd0,   7'd127, 15'd0},      // R6 a zero
        {8'd255, 7'd0,   15'd0}       // R6 b zero
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected %0d", cycles, 200000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] pa;
        logic [6:0] pb;
        repeat (3) @(negedge clk);
        // R5 reset state
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        check(prod == 15'd0, "R5", int'(prod), 0);
        rst = 1'b0;

        // vector table
        for (int v = 0; v < N_VEC; v++) begin
            op_a = VEC[v][29:22];
            op_b = VEC[v][21:15];
            in_valid = 1'b1;
            @(negedge clk);
            check(prod == VEC[v][14:0], "R1/R2/R3/R6/R7 vector", int'(prod), int'(VEC[v][14:0]));
            check(out_valid == 1'b1, "R4", int'(out_valid), 1);
        end

        // R4: valid low then high again
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        in_valid = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1, "R4", int'(out_valid), 1);

        // R5: reset with live inputs clears the stage
        op_a = 8'd255; op_b = 7'd127; in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R5", int'(out_valid), 0);
        check(prod == 15'd0, "R5", int'(prod), 0);
        rst = 1'b0;

        // R1 exhaustive sweep, streamed one pair per cycle
        pa = '0; pb = '0;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 128; ib++) begin
                op_a = 8'(ia);
                op_b = 7'(ib);
                in_valid = 1'b1;
                @(negedge clk);
                check(prod == 15'(ia * ib), "R1 sweep", int'(prod), ia * ib);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule